// File: doc/BRIEF.md
# Way-Predicting Two-Way Read Cache

This block is a small read-only data cache with two ways per set and a single steering bit per set. The steering bit names the way to read first. A read that finds its line in the steered way returns on the next cycle. A read that finds its line only in the other way pays for a second lookup. A read that finds the line in neither way fetches the whole line from a backing memory over a one-shot request and a line-wide response. The line is then written into the least recently used way of its set.

A client issues one byte address with a valid/ready handshake and receives one 32-bit word with a single-cycle response strobe. Only one read is in flight at a time. Three event counters report how many reads completed as steered hits, unsteered hits and fills, so that a trace can be compared against a reference model.

With default parameters the cache holds 128 bytes as 4 sets of two 16-byte lines.

Top module: `way_pred_cache`

## Requirements
- R1: After reset every line is invalid, every steering bit and every LRU bit points at way 0, `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0 and all three counters are 0.
- R2: Address bits [7:6] are the tag, [5:4] the set, [3:2] the word within the line and [1:0] are ignored. `resp_data` is bits [32w+31:32w] of the line, where w is the word field.
- R3: A read whose line sits in the steered way raises `resp_valid` in the cycle after acceptance (cycle 2, counting the acceptance cycle as 1) and issues no memory request.
- R4: A read whose line sits only in the unsteered way raises `resp_valid` in cycle 4, issues no memory request, and sets the set's steering bit to that way.
- R5: A read that misses both ways pulses `mem_req_valid` for exactly one cycle in cycle 2, with `mem_req_addr` equal to the read address with bits [3:0] cleared. It raises `resp_valid` in the cycle after `mem_resp_valid`. With the bench's memory returning in cycle 59, the response is in cycle 60.
- R6: A miss writes the returned line into the least recently used way of its set, whatever the steering bit says, and then points the steering bit at that way.
- R7: Every hit and every fill makes the way it used the most recent one in its set, so the next fill in that set picks the other way.
- R8: `req_ready` is low from the cycle after acceptance until the response cycle, and is high again in the response cycle.
- R9: `fast_hits`, `slow_hits` and `misses` each grow by one for each read completed on their path, and the new value is visible in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a read |
| req_addr | input | 8 | Byte address of the read |
| resp_valid | output | 1 | One-cycle strobe: `resp_data` holds the read word |
| resp_data | output | 32 | Word read |
| mem_req_valid | output | 1 | One-cycle line fetch request |
| mem_req_addr | output | 8 | Line-aligned address of the fetch |
| mem_resp_valid | input | 1 | Fetched line present |
| mem_resp_line | input | 128 | Fetched line, word 0 in the low bits |
| fast_hits | output | 16 | Count of steered-way hits |
| slow_hits | output | 16 | Count of other-way hits |
| misses | output | 16 | Count of line fills |

## Verification
Each read is driven at a falling edge, so acceptance happens at the next rising edge. The bench then counts falling edges from cycle 2 until `resp_valid` is seen. The cycle at which it is seen must be 2, 4 or 60, matching the path that an independent model of tags, LRU and steering bits predicts. Data, counters and `req_ready` are sampled in that same response cycle, because all of them change at the edge that raises the strobe. The bench memory counts 57 falling edges after it sees the request in cycle 2, so the line is present in cycle 59. The number and address of memory requests are compared after each read.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOW1,
      ST_SLOW2,
      ST_FREQ,
      ST_FWAIT
   } wpc_state_e;

   localparam int EV_FAST = 0;
   localparam int EV_SLOW = 1;
   localparam int EV_MISS = 2;
   localparam int NUM_EV  = 3;

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
   parameter int NUM_SETS = 4,
   parameter int NUM_WAYS = 2,
   parameter int TAG_W    = 2,
   parameter int IDX_W    = $clog2(NUM_SETS),
   parameter int WAY_W    = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    idx,
   input  logic [TAG_W-1:0]    tag,
   input  logic                fill_en,
   input  logic [WAY_W-1:0]    fill_way,
   output logic [NUM_WAYS-1:0] hit
);

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [NUM_SETS-1:0] vld_q;
      logic [TAG_W-1:0]    tag_q [NUM_SETS];
      logic                sel;

      assign sel = fill_en && (fill_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
         end else if (sel) begin
            vld_q[idx] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[idx] <= tag;
         end
      end

      assign hit[w] = vld_q[idx] && (tag_q[idx] == tag);
   end

   // R6
   hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
   parameter int NUM_SETS = 4,
   parameter int NUM_WAYS = 2,
   parameter int WORD_W   = 32,
   parameter int WORDS    = 4,
   parameter int IDX_W    = $clog2(NUM_SETS),
   parameter int WAY_W    = $clog2(NUM_WAYS),
   parameter int WSEL_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
   parameter int LINE_W   = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WSEL_W-1:0] wsel,
   input  logic [WAY_W-1:0]  rd_way,
   input  logic              fill_en,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [LINE_W-1:0] fill_line,
   output logic [WORD_W-1:0] rd_word
);

   logic [LINE_W-1:0] way_line [NUM_WAYS];
   logic [LINE_W-1:0] sel_line;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [LINE_W-1:0] line_q [NUM_SETS];

      always_ff @(posedge clk) begin
         if (fill_en && (fill_way == WAY_W'(w))) begin
            line_q[idx] <= fill_line;
         end
      end

      assign way_line[w] = line_q[idx];
   end

   assign sel_line = way_line[rd_way];

   if (WORDS > 1) begin : g_wmux
      assign rd_word = sel_line[wsel*WORD_W +: WORD_W];
   end else begin : g_wone
      logic unused_wsel;
      assign unused_wsel = ^wsel;
      assign rd_word     = sel_line[WORD_W-1:0];
   end

endmodule

// File: rtl/wpc_policy_bits.sv
module wpc_policy_bits #(
   parameter int NUM_SETS = 4,
   parameter int IDX_W    = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             touch_en,
   input  logic             touch_way,
   input  logic             steer_en,
   output logic             pred_way,
   output logic             lru_way
);

   logic [NUM_SETS-1:0] pred_q;
   logic [NUM_SETS-1:0] lru_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_q <= '0;
         lru_q  <= '0;
      end else if (touch_en) begin
         lru_q[idx] <= ~touch_way;
         if (steer_en) begin
            pred_q[idx] <= touch_way;
         end
      end
   end

   assign pred_way = pred_q[idx];
   assign lru_way  = lru_q[idx];

   // R7
   policy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !touch_en |=> ($stable(lru_q) && $stable(pred_q)));

endmodule

// File: rtl/wpc_event_ctr.sv
module wpc_event_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc) begin
         count <= count + CNT_W'(1);
      end
   end

endmodule

// File: rtl/way_pred_cache.sv
module way_pred_cache
   import wpc_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int LINE_BYTES = 16,
   parameter int NUM_SETS   = 4,
   parameter int NUM_WAYS   = 2,
   parameter int WORD_W     = 32,
   parameter int CNT_W      = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [ADDR_W-1:0]       req_addr,
   output logic                    resp_valid,
   output logic [WORD_W-1:0]       resp_data,
   output logic                    mem_req_valid,
   output logic [ADDR_W-1:0]       mem_req_addr,
   input  logic                    mem_resp_valid,
   input  logic [LINE_BYTES*8-1:0] mem_resp_line,
   output logic [CNT_W-1:0]        fast_hits,
   output logic [CNT_W-1:0]        slow_hits,
   output logic [CNT_W-1:0]        misses
);

   localparam int LINE_W     = LINE_BYTES * 8;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int WORDS      = LINE_BYTES / WORD_BYTES;
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int BSEL_W     = $clog2(WORD_BYTES);
   localparam int WSEL_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int IDX_W      = $clog2(NUM_SETS);
   localparam int LN_W       = ADDR_W - OFF_W;
   localparam int TAG_W      = LN_W - IDX_W;
   localparam int WAY_W      = 1;

   // elaboration checks
   if (NUM_WAYS != 2) begin : g_bad_ways
      $error("one steering bit per set needs exactly two ways");
   end
   if ((1 << IDX_W) != NUM_SETS || IDX_W < 1) begin : g_bad_sets
      $error("set count must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end
   if ((WORD_W % 8) != 0 || (LINE_BYTES % WORD_BYTES) != 0) begin : g_bad_word
      $error("line must hold a whole number of byte-sized words");
   end

   wpc_state_e          state_q;
   logic [LN_W-1:0]     cur_line_q;
   logic [WSEL_W-1:0]   cur_wsel_q;
   logic                resp_valid_q;
   logic [WORD_W-1:0]   resp_data_q;

   logic [LN_W-1:0]     req_line;
   logic [WSEL_W-1:0]   req_wsel;
   logic [LN_W-1:0]     lk_line;
   logic [WSEL_W-1:0]   lk_wsel;
   logic [IDX_W-1:0]    lk_idx;
   logic [TAG_W-1:0]    lk_tag;

   logic [NUM_WAYS-1:0] hit;
   logic                pred_way;
   logic                lru_way;
   logic                hit_way;
   logic                accept;
   logic                fast_hit;
   logic                slow_hit;
   logic                fill_en;
   logic                touch_en;
   logic                touch_way;
   logic                rd_way;
   logic [WORD_W-1:0]   rd_word;
   logic [WORD_W-1:0]   fill_word;
   logic [NUM_EV-1:0]   ev_inc;
   logic [CNT_W-1:0]    ev_count [NUM_EV];

   // address fields
   assign req_line = req_addr[ADDR_W-1:OFF_W];

   if (WORDS > 1) begin : g_req_wsel
      assign req_wsel = req_addr[BSEL_W +: WSEL_W];
   end else begin : g_req_nowsel
      assign req_wsel = '0;
   end

   if (BSEL_W > 0) begin : g_bsel_sink
      logic unused_bsel;
      assign unused_bsel = ^req_addr[BSEL_W-1:0];
   end

   assign lk_line = (state_q == ST_IDLE) ? req_line : cur_line_q;
   assign lk_wsel = (state_q == ST_IDLE) ? req_wsel : cur_wsel_q;
   assign lk_idx  = lk_line[IDX_W-1:0];
   assign lk_tag  = lk_line[LN_W-1:IDX_W];

   // lookup and path decision
   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign hit_way   = hit[1];
   assign fast_hit  = hit[pred_way];
   assign slow_hit  = (|hit) && !fast_hit;
   assign fill_en   = (state_q == ST_FWAIT) && mem_resp_valid;
   assign rd_way    = (state_q == ST_IDLE) ? pred_way : hit_way;

   always_comb begin
      touch_en  = 1'b0;
      touch_way = pred_way;
      unique case (state_q)
         ST_IDLE: begin
            touch_en  = accept && fast_hit;
            touch_way = pred_way;
         end
         ST_SLOW2: begin
            touch_en  = 1'b1;
            touch_way = hit_way;
         end
         ST_FWAIT: begin
            touch_en  = mem_resp_valid;
            touch_way = lru_way;
         end
         default: begin
            touch_en  = 1'b0;
            touch_way = pred_way;
         end
      endcase
   end

   if (WORDS > 1) begin : g_fill_wmux
      assign fill_word = mem_resp_line[cur_wsel_q*WORD_W +: WORD_W];
   end else begin : g_fill_wone
      assign fill_word = mem_resp_line[WORD_W-1:0];
   end

   // storage
   wpc_tag_store #(
      .NUM_SETS (NUM_SETS),
      .NUM_WAYS (NUM_WAYS),
      .TAG_W    (TAG_W),
      .IDX_W    (IDX_W),
      .WAY_W    (WAY_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (lk_idx),
      .tag      (lk_tag),
      .fill_en  (fill_en),
      .fill_way (lru_way),
      .hit      (hit)
   );

   wpc_data_store #(
      .NUM_SETS (NUM_SETS),
      .NUM_WAYS (NUM_WAYS),
      .WORD_W   (WORD_W),
      .WORDS    (WORDS),
      .IDX_W    (IDX_W),
      .WAY_W    (WAY_W),
      .WSEL_W   (WSEL_W),
      .LINE_W   (LINE_W)
   ) u_data (
      .clk       (clk),
      .idx       (lk_idx),
      .wsel      (lk_wsel),
      .rd_way    (rd_way),
      .fill_en   (fill_en),
      .fill_way  (lru_way),
      .fill_line (mem_resp_line),
      .rd_word   (rd_word)
   );

   wpc_policy_bits #(
      .NUM_SETS (NUM_SETS),
      .IDX_W    (IDX_W)
   ) u_policy (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (lk_idx),
      .touch_en  (touch_en),
      .touch_way (touch_way),
      .steer_en  (state_q != ST_IDLE),
      .pred_way  (pred_way),
      .lru_way   (lru_way)
   );

   // access sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cur_line_q   <= '0;
         cur_wsel_q   <= '0;
         resp_valid_q <= 1'b0;
         resp_data_q  <= '0;
      end else begin
         resp_valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  cur_line_q <= req_line;
                  cur_wsel_q <= req_wsel;
                  if (fast_hit) begin
                     resp_valid_q <= 1'b1;
                     resp_data_q  <= rd_word;
                  end else if (slow_hit) begin
                     state_q <= ST_SLOW1;
                  end else begin
                     state_q <= ST_FREQ;
                  end
               end
            end
            ST_SLOW1: state_q <= ST_SLOW2;
            ST_SLOW2: begin
               resp_valid_q <= 1'b1;
               resp_data_q  <= rd_word;
               state_q      <= ST_IDLE;
            end
            ST_FREQ: state_q <= ST_FWAIT;
            ST_FWAIT: begin
               if (mem_resp_valid) begin
                  resp_valid_q <= 1'b1;
                  resp_data_q  <= fill_word;
                  state_q      <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign resp_valid    = resp_valid_q;
   assign resp_data     = resp_data_q;
   assign mem_req_valid = (state_q == ST_FREQ);
   assign mem_req_addr  = {cur_line_q, {OFF_W{1'b0}}};

   // event counters
   assign ev_inc[EV_FAST] = accept && fast_hit;
   assign ev_inc[EV_SLOW] = (state_q == ST_SLOW2);
   assign ev_inc[EV_MISS] = fill_en;

   for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
      wpc_event_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ev_inc[e]),
         .count (ev_count[e])
      );
   end

   assign fast_hits = ev_count[EV_FAST];
   assign slow_hits = ev_count[EV_SLOW];
   assign misses    = ev_count[EV_MISS];

   // R3
   fast_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && fast_hit) |=> (resp_valid && !mem_req_valid));

   // R4
   slow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && slow_hit) |=> !resp_valid ##1 !resp_valid ##1 resp_valid);

   // R5
   memreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   // R5
   fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> resp_valid);

   // R8
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !fast_hit) |=> !req_ready);

   // R8
   resp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> req_ready);

   // R9
   ev_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_inc != '0) |=> resp_valid);

endmodule

// File: tb/way_pred_cache_tb.sv
module way_pred_cache_tb;

   localparam int CLK_HALF = 4;
   localparam int MEM_LAT  = 57;
   localparam int LAT_FAST = 2;
   localparam int LAT_SLOW = 4;
   localparam int LAT_MISS = 60;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [7:0]   req_addr = '0;
   logic         resp_valid;
   logic [31:0]  resp_data;
   logic         mem_req_valid;
   logic [7:0]   mem_req_addr;
   logic         mem_resp_valid = 1'b0;
   logic [127:0] mem_resp_line = '0;
   logic [15:0]  fast_hits, slow_hits, misses;

   always #CLK_HALF clk = ~clk;

   way_pred_cache u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_addr       (req_addr),
      .resp_valid     (resp_valid),
      .resp_data      (resp_data),
      .mem_req_valid  (mem_req_valid),
      .mem_req_addr   (mem_req_addr),
      .mem_resp_valid (mem_resp_valid),
      .mem_resp_line  (mem_resp_line),
      .fast_hits      (fast_hits),
      .slow_hits      (slow_hits),
      .misses         (misses)
   );

   int n_run  = 0;
   int n_fail = 0;

   // backing memory content, word aligned
   function automatic logic [31:0] mem_word(input logic [7:0] a);
      logic [7:0] b;
      b = {a[7:2], 2'b00};
      return {8'h5A, b, ~b, b ^ 8'h3C};
   endfunction

   function automatic logic [127:0] mem_line(input logic [7:0] a);
      logic [127:0] l;
      for (int i = 0; i < 4; i++) l[32*i +: 32] = mem_word({a[7:4], 2'(i), 2'b00});
      return l;
   endfunction

   // memory model: request seen mid cycle 2, line present in cycle 59
   int         mcnt = 0;
   int         mem_reqs = 0;
   logic [7:0] mline = '0;

   always @(negedge clk) begin
      mem_resp_valid <= 1'b0;
      if (mem_req_valid) begin
         mcnt     <= MEM_LAT;
         mline    <= mem_req_addr;
         mem_reqs <= mem_reqs + 1;
      end else if (mcnt > 0) begin
         mcnt <= mcnt - 1;
         if (mcnt == 1) begin
            mem_resp_valid <= 1'b1;
            mem_resp_line  <= mem_line(mline);
         end
      end
   end

   // reference model
   bit       m_vld  [4][2];
   bit [1:0] m_tag  [4][2];
   bit       m_lru  [4];
   bit       m_pred [4];
   int       e_fast = 0, e_slow = 0, e_miss = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // kind: 0 steered hit, 1 other-way hit, 2 miss
   task automatic do_read(input logic [7:0] a, input int want_kind);
      int         kind, hw, lat, cyc, reqs0;
      bit         busy_ok;
      logic [1:0] idx, tg;
      string      rq;
      idx  = a[5:4];
      tg   = a[7:6];
      hw   = -1;
      for (int w = 0; w < 2; w++) if (m_vld[idx][w] && m_tag[idx][w] == tg) hw = w;
      if (hw == int'(m_pred[idx])) begin
         kind = 0; lat = LAT_FAST; e_fast++; rq = "R3";
      end else if (hw >= 0) begin
         kind = 1; lat = LAT_SLOW; e_slow++; rq = "R4"; m_pred[idx] = 1'(hw);
      end else begin
         kind = 2; lat = LAT_MISS; e_miss++; rq = "R5"; hw = int'(m_lru[idx]);
         m_vld[idx][hw] = 1'b1; m_tag[idx][hw] = tg; m_pred[idx] = 1'(hw);
      end
      m_lru[idx] = ~1'(hw);
      // R6 R7: model path must match the scenario's intent
      chk(kind == want_kind, "R7", $sformatf("model path for %02h", a), kind, want_kind);

      reqs0 = mem_reqs;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8", "ready before request", req_ready, 1);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      cyc       = 2;
      busy_ok   = 1'b1;
      while (!resp_valid && cyc < 100) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         cyc++;
      end
      chk(cyc == lat, rq, $sformatf("response cycle for %02h", a), cyc, lat);
      chk(busy_ok, "R8", "ready low while busy", busy_ok, 1);
      chk(req_ready == 1'b1, "R8", "ready in response cycle", req_ready, 1);
      chk(resp_data == mem_word(a), "R2", $sformatf("data for %02h", a), resp_data, mem_word(a));
      chk(fast_hits == 16'(e_fast), "R9", "fast count", fast_hits, e_fast);
      chk(slow_hits == 16'(e_slow), "R9", "slow count", slow_hits, e_slow);
      chk(misses == 16'(e_miss), "R9", "miss count", misses, e_miss);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R9", "strobe one cycle", resp_valid, 0);
      chk(mem_reqs - reqs0 == ((kind == 2) ? 1 : 0), rq, "memory request count",
          mem_reqs - reqs0, (kind == 2) ? 1 : 0);
      if (kind == 2)
         chk(mline == {a[7:4], 4'h0}, "R5", "fetch address", mline, {a[7:4], 4'h0});
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      chk(resp_valid == 1'b0, "R1", "no response after reset", resp_valid, 0);
      chk(mem_req_valid == 1'b0, "R1", "no fetch after reset", mem_req_valid, 0);
      chk({fast_hits, slow_hits, misses} == '0, "R1", "counters after reset",
          {fast_hits, slow_hits, misses}, 0);
   endtask

   task automatic t_cold_and_fast();
      do_read(8'h04, 2);   // R1 cold miss, R6 fills way 0
      do_read(8'h08, 0);   // R3 steered hit, word 2
      do_read(8'h0F, 0);   // R2 byte bits ignored, word 3
      do_read(8'h01, 0);   // R2 word 0
   endtask

   task automatic t_slow_and_steer();
      do_read(8'h44, 2);   // R6 second tag fills way 1, steering to 1
      do_read(8'h04, 1);   // R4 line in way 0, steered to way 1
      do_read(8'h00, 0);   // R4 steering now points at way 0
   endtask

   task automatic t_lru_evict();
      do_read(8'h84, 2);   // R7 way 1 is least recent, evicted
      do_read(8'h48, 2);   // R7 evicted tag refetched into way 0
      do_read(8'h88, 1);   // R4 way 1 kept its line
      do_read(8'h4C, 1);   // R4
   endtask

   task automatic t_other_sets();
      do_read(8'h14, 2);
      do_read(8'h94, 2);
      do_read(8'h18, 1);
      do_read(8'hE0, 2);   // R6 set 2
      do_read(8'hE4, 0);
      do_read(8'h38, 2);   // R6 set 3
      do_read(8'hB0, 2);
      do_read(8'h3C, 1);
      do_read(8'hD4, 2);   // R7 set 1 evicts least recent
      do_read(8'h98, 2);
   endtask

   initial begin
      #(CLK_HALF * 2 * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int s = 0; s < 4; s++) begin
         m_lru[s] = 1'b0; m_pred[s] = 1'b0;
         for (int w = 0; w < 2; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cold_and_fast();
      t_slow_and_steer();
      t_lru_evict();
      t_other_sets();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule